// File: doc/BRIEF.md
# Frame Base Update Interrupt Unit

This block keeps the start address of the frame buffer used by a display controller and signals when a new address has come into use. Software may write a new base address at any moment. The value goes into a shadow register first. On the next frame-start strobe from the timing generator, the block copies the shadow into the active register. In that same cycle it sets a "base taken" status bit. Display software treats this event as its only vertical-blanking indication.

A single register write port carries the base address, the interrupt enable mask, a write-one-to-clear word and a control word. The control word holds a controller-enable bit and a panel-power bit, and the block enforces the order in which these two bits may change. A registered read port returns the masked status, the raw status, the enable mask, the control word and both addresses. The interrupt line is the OR of every status bit that is both raised and enabled.

Top module: `fb_base_irq_unit`

## Requirements
- R1: After reset the shadow and active addresses, the raw status, the enable mask and both control bits are zero, and `irq` is low.
- R2: A write with `wr_sel`=0 loads the shadow address with the two low bits forced to zero. `active_base` does not change until a frame-start strobe.
- R3: A `frame_start` cycle that follows an untransferred base write copies the shadow into `active_base`, and in that same cycle it sets raw status bit 2. A base write in the same cycle as `frame_start` is held for the next strobe.
- R4: When several base writes come before one strobe, only the last value is transferred, and the event is raised once.
- R5: A `frame_start` with no pending base write leaves `active_base` and the raw status unchanged.
- R6: A write with `wr_sel`=1 sets the enable mask. Only bit 2 is stored, and writing zero disables all sources. Masked status is raw AND enable.
- R7: A write with `wr_sel`=2 clears each raw status bit that is 1 in the written word. Bits written as 0 are left unchanged.
- R8: When a raise and a clear of bit 2 fall in the same cycle, the bit ends up set.
- R9: `irq` is high exactly when the masked status is nonzero.
- R10: A write with `wr_sel`=3 uses bit 0 as enable and bit 1 as power. Power becomes 1 only if enable was already 1 and the write keeps it at 1. While power is 1, a request to clear enable drops power and leaves enable at 1.
- R11: `rd_data` shows, one cycle after `rd_sel`, the selected value. The selects are 0 masked status, 1 raw status, 2 enable mask, 3 control, 4 active address and 5 shadow address. Selects 6 and 7 return zero.
- R12: Writes with `wr_sel` 4 to 7 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register write select |
| wr_data | input | 32 | Register write data |
| rd_sel | input | 3 | Register read select |
| rd_data | output | 32 | Registered read data |
| frame_start | input | 1 | One-cycle frame boundary strobe from the timing generator |
| active_base | output | 32 | Base address in use by the fetch logic |
| ctrl_enable | output | 1 | Controller enable |
| ctrl_power | output | 1 | Panel power |
| irq | output | 1 | Interrupt request |

## Verification
The status-raise path and the write-one-to-clear path can act on the same bit in the same cycle. The bench provokes this collision by issuing a clear write of bit 2 in the cycle of a frame-start strobe that completes a pending transfer. It then reads back the raw status and observes `irq`, and expects the bit set and the line high. A second collision case puts a base write in the same cycle as the strobe. The bench judges it by whether `active_base` stays put until the following strobe.

// File: rtl/fbu_pkg.sv
package fbu_pkg;
  localparam int ADDR_W       = 32;
  localparam int SEL_W        = 3;
  localparam int STAT_W       = 5;
  localparam int UPD_BIT      = 2;
  localparam int ALIGN_BITS   = 2;
  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_PWR_BIT = 1;

  typedef enum logic [SEL_W-1:0] {
    WR_BASE  = 3'd0,
    WR_IEN   = 3'd1,
    WR_ICLR  = 3'd2,
    WR_CTRL  = 3'd3
  } wr_sel_e;

  typedef enum logic [SEL_W-1:0] {
    RD_MSTAT  = 3'd0,
    RD_RSTAT  = 3'd1,
    RD_IEN    = 3'd2,
    RD_CTRL   = 3'd3,
    RD_ACTIVE = 3'd4,
    RD_SHADOW = 3'd5
  } rd_sel_e;
endpackage

// File: rtl/fbu_base_buffer.sv
module fbu_base_buffer #(
  parameter int ADDR_W     = 32,
  parameter int ALIGN_BITS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              base_we,
  input  logic [ADDR_W-1:0] base_wdata,
  input  logic              frame_start,
  output logic [ADDR_W-1:0] shadow_o,
  output logic [ADDR_W-1:0] active_o,
  output logic              taken_o
);
  localparam int HI_W = ADDR_W - ALIGN_BITS;

  logic [ADDR_W-1:0] shadow_q;
  logic [ADDR_W-1:0] active_q;
  logic              pending_q;

  assign taken_o = frame_start & pending_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q  <= '0;
      active_q  <= '0;
      pending_q <= 1'b0;
    end else begin
      if (base_we)
        shadow_q <= {base_wdata[ADDR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
      if (taken_o)
        active_q <= shadow_q;
      if (frame_start)
        pending_q <= base_we;
      else if (base_we)
        pending_q <= 1'b1;
    end
  end

  assign shadow_o = shadow_q;
  assign active_o = active_q;

  // R3
  xfer_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_start && pending_q) |=> (active_q == $past(shadow_q)));

  // R2
  active_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> $stable(active_q));

  // R2
  align_chk: assert property (@(posedge clk) disable iff (rst)
    shadow_q[ALIGN_BITS-1:0] == '0);

  logic unused_hi;
  assign unused_hi = ^base_wdata[ALIGN_BITS-1:0] ^ (HI_W == 0);
endmodule

// File: rtl/fbu_irq_ctrl.sv
module fbu_irq_ctrl #(
  parameter int STAT_W  = 5,
  parameter int UPD_BIT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ien_we,
  input  logic              iclr_we,
  input  logic [STAT_W-1:0] wdata,
  input  logic              raise,
  output logic [STAT_W-1:0] raw_o,
  output logic [STAT_W-1:0] en_o,
  output logic [STAT_W-1:0] masked_o,
  output logic              irq_o
);
  logic [STAT_W-1:0] raw_d, en_d;
  logic [STAT_W-1:0] raw_q, en_q;
  logic              irq_q;

  for (genvar i = 0; i < STAT_W; i++) begin : g_bit
    if (i == UPD_BIT) begin : g_live
      always_comb begin
        en_d[i]  = ien_we ? wdata[i] : en_q[i];
        raw_d[i] = raise | (raw_q[i] & ~(iclr_we & wdata[i]));
      end
      always_ff @(posedge clk) begin
        if (rst) begin
          raw_q[i] <= 1'b0;
          en_q[i]  <= 1'b0;
        end else begin
          raw_q[i] <= raw_d[i];
          en_q[i]  <= en_d[i];
        end
      end
    end else begin : g_tied
      assign en_d[i]  = 1'b0;
      assign raw_d[i] = 1'b0;
      assign raw_q[i] = 1'b0;
      assign en_q[i]  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(raw_d & en_d);
  end

  assign raw_o    = raw_q;
  assign en_o     = en_q;
  assign masked_o = raw_q & en_q;
  assign irq_o    = irq_q;

  // R8
  raise_wins_chk: assert property (@(posedge clk) disable iff (rst)
    raise |=> raw_q[UPD_BIT]);

  // R7
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    (iclr_we && wdata[UPD_BIT] && !raise) |=> !raw_q[UPD_BIT]);
endmodule

// File: rtl/fbu_ctrl_seq.sv
module fbu_ctrl_seq (
  input  logic clk,
  input  logic rst,
  input  logic ctrl_we,
  input  logic req_en,
  input  logic req_pwr,
  output logic en_o,
  output logic pwr_o
);
  logic en_q, pwr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      pwr_q <= 1'b0;
    end else if (ctrl_we) begin
      pwr_q <= req_pwr & req_en & en_q;
      en_q  <= req_en | pwr_q;
    end
  end

  assign en_o  = en_q;
  assign pwr_o = pwr_q;

  // R10
  pwr_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
    pwr_q |-> en_q);

  // R10
  pwr_after_en_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pwr_q) |-> $past(en_q));

  // R10
  en_after_pwr_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(en_q) |-> !$past(pwr_q));
endmodule

// File: rtl/fb_base_irq_unit.sv
module fb_base_irq_unit
  import fbu_pkg::*;
#(
  parameter int P_ADDR_W = ADDR_W,
  parameter int P_STAT_W = STAT_W,
  parameter int P_UPD    = UPD_BIT
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [SEL_W-1:0]    wr_sel,
  input  logic [P_ADDR_W-1:0] wr_data,
  input  logic [SEL_W-1:0]    rd_sel,
  output logic [P_ADDR_W-1:0] rd_data,
  input  logic                frame_start,
  output logic [P_ADDR_W-1:0] active_base,
  output logic                ctrl_enable,
  output logic                ctrl_power,
  output logic                irq
);
  localparam int PAD_W = P_ADDR_W - P_STAT_W;

  logic base_we, ien_we, iclr_we, ctrl_we;
  logic taken;
  logic [P_ADDR_W-1:0] shadow;
  logic [P_STAT_W-1:0] raw_stat, en_mask, masked;
  logic [P_ADDR_W-1:0] ctrl_word;
  logic [P_ADDR_W-1:0] rd_d, rd_q;

  always_comb begin
    base_we = wr_en && (wr_sel == WR_BASE);
    ien_we  = wr_en && (wr_sel == WR_IEN);
    iclr_we = wr_en && (wr_sel == WR_ICLR);
    ctrl_we = wr_en && (wr_sel == WR_CTRL);
  end

  fbu_base_buffer #(.ADDR_W(P_ADDR_W), .ALIGN_BITS(ALIGN_BITS)) u_base (
    .clk(clk), .rst(rst), .base_we(base_we), .base_wdata(wr_data),
    .frame_start(frame_start), .shadow_o(shadow), .active_o(active_base),
    .taken_o(taken));

  fbu_irq_ctrl #(.STAT_W(P_STAT_W), .UPD_BIT(P_UPD)) u_irq (
    .clk(clk), .rst(rst), .ien_we(ien_we), .iclr_we(iclr_we),
    .wdata(wr_data[P_STAT_W-1:0]), .raise(taken), .raw_o(raw_stat),
    .en_o(en_mask), .masked_o(masked), .irq_o(irq));

  fbu_ctrl_seq u_ctrl (
    .clk(clk), .rst(rst), .ctrl_we(ctrl_we),
    .req_en(wr_data[CTRL_EN_BIT]), .req_pwr(wr_data[CTRL_PWR_BIT]),
    .en_o(ctrl_enable), .pwr_o(ctrl_power));

  always_comb begin
    ctrl_word = '0;
    ctrl_word[CTRL_EN_BIT]  = ctrl_enable;
    ctrl_word[CTRL_PWR_BIT] = ctrl_power;
  end

  always_comb begin
    case (rd_sel)
      RD_MSTAT:  rd_d = {{PAD_W{1'b0}}, masked};
      RD_RSTAT:  rd_d = {{PAD_W{1'b0}}, raw_stat};
      RD_IEN:    rd_d = {{PAD_W{1'b0}}, en_mask};
      RD_CTRL:   rd_d = ctrl_word;
      RD_ACTIVE: rd_d = active_base;
      RD_SHADOW: rd_d = shadow;
      default:   rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_d;
  end

  assign rd_data = rd_q;

  // R9
  irq_level_chk: assert property (@(posedge clk) disable iff (rst)
    irq == (|masked));

  // R11
  rd_lat_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_sel == RD_ACTIVE) |=> (rd_data == $past(active_base)));
endmodule

// File: tb/fb_base_irq_unit_tb.sv
module fb_base_irq_unit_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } sb_item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic        frame_start = 1'b0;
  logic [31:0] active_base;
  logic        ctrl_enable, ctrl_power, irq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  sb_item_t sbq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  fb_base_irq_unit u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .frame_start(frame_start),
    .active_base(active_base), .ctrl_enable(ctrl_enable),
    .ctrl_power(ctrl_power), .irq(irq));

  // monitor: compares registered read data after the edge that produced it
  always @(posedge clk) begin
    #1;
    if (sbq.size() > 0) begin
      sb_item_t it;
      it = sbq.pop_front();
      checks++;
      if (rd_data !== it.exp) begin
        errors++;
        $display("FAIL %s rd_data got %h expected %h", it.tag, rd_data, it.exp);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic [2:0] sel, input logic [31:0] exp, input string tag);
    sb_item_t it;
    rd_sel = sel;
    it.exp = exp; it.tag = tag;
    sbq.push_back(it);
    @(negedge clk);
  endtask

  task automatic frame();
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 active", active_base, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 ctrl", {30'b0, ctrl_power, ctrl_enable}, 32'h0);
    for (int s = 0; s < 6; s++) rd(3'(s), 32'h0, "R1 regs");
    rd(3'd6, 32'h0, "R11 unused sel");

    // R2 shadow write, alignment, active held
    wr(3'd0, 32'h1000_0003);
    rd(3'd5, 32'h1000_0000, "R2 shadow aligned");
    chk("R2 active held", active_base, 32'h0);

    // R6 enable mask: only bit 2 stored
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd2, 32'h4, "R6 enable mask");

    // R3 transfer and raise at frame start
    frame();
    chk("R3 active", active_base, 32'h1000_0000);
    chk("R9 irq high", {31'b0, irq}, 32'h1);
    rd(3'd1, 32'h4, "R3 raw");
    rd(3'd0, 32'h4, "R6 masked");

    // R7 clear semantics
    wr(3'd2, 32'h0000_0003);
    rd(3'd1, 32'h4, "R7 zero bits keep");
    wr(3'd2, 32'h0000_0004);
    rd(3'd1, 32'h0, "R7 cleared");
    chk("R9 irq low", {31'b0, irq}, 32'h0);

    // R5 frame without pending write
    frame();
    chk("R5 active same", active_base, 32'h1000_0000);
    rd(3'd1, 32'h0, "R5 no raise");

    // R4 several writes, last one wins, one event
    wr(3'd0, 32'h0000_00A0);
    wr(3'd0, 32'h0000_00B0);
    wr(3'd0, 32'h0000_00C7);
    chk("R4 active before", active_base, 32'h1000_0000);
    frame();
    chk("R4 last value", active_base, 32'h0000_00C4);
    wr(3'd2, 32'h4);
    frame();
    rd(3'd1, 32'h0, "R4 single event");

    // R6 / R9 disable masks irq while raw remains
    wr(3'd0, 32'h0000_0200);
    frame();
    wr(3'd1, 32'h0);
    rd(3'd0, 32'h0, "R6 masked off");
    rd(3'd1, 32'h4, "R6 raw kept");
    chk("R9 irq masked", {31'b0, irq}, 32'h0);
    wr(3'd1, 32'h4);
    chk("R9 irq re-enabled", {31'b0, irq}, 32'h1);
    wr(3'd2, 32'h4);

    // R8 raise and clear in the same cycle
    wr(3'd0, 32'h0000_0300);
    frame_start = 1'b1;
    wr(3'd2, 32'h4);
    frame_start = 1'b0;
    rd(3'd1, 32'h4, "R8 raise wins");
    chk("R8 irq", {31'b0, irq}, 32'h1);
    chk("R8 active", active_base, 32'h0000_0300);
    wr(3'd2, 32'h4);

    // R3 write in the strobe cycle waits for the next strobe
    frame_start = 1'b1;
    wr(3'd0, 32'h0000_0400);
    frame_start = 1'b0;
    chk("R3 same-cycle held", active_base, 32'h0000_0300);
    rd(3'd1, 32'h0, "R3 same-cycle no raise");
    frame();
    chk("R3 next strobe", active_base, 32'h0000_0400);
    wr(3'd2, 32'h4);

    // R12 unused write selects
    wr(3'd5, 32'hFFFF_FFFF);
    wr(3'd7, 32'hFFFF_FFFF);
    rd(3'd5, 32'h0000_0400, "R12 shadow");
    rd(3'd2, 32'h4, "R12 enable");
    rd(3'd1, 32'h0, "R12 raw");
    rd(3'd3, 32'h0, "R12 ctrl");

    // R10 control ordering
    wr(3'd3, 32'h2);
    chk("R10 pwr without en", {30'b0, ctrl_power, ctrl_enable}, 32'h0);
    wr(3'd3, 32'h3);
    chk("R10 en first", {30'b0, ctrl_power, ctrl_enable}, 32'h1);
    wr(3'd3, 32'h3);
    chk("R10 pwr on", {30'b0, ctrl_power, ctrl_enable}, 32'h3);
    rd(3'd3, 32'h3, "R10 ctrl read");
    wr(3'd3, 32'h0);
    chk("R10 pwr off first", {30'b0, ctrl_power, ctrl_enable}, 32'h1);
    wr(3'd3, 32'h0);
    chk("R10 en off", {30'b0, ctrl_power, ctrl_enable}, 32'h0);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule